// File: doc/BRIEF.md
# Deadline-Ordered Flash Request Dispatcher

This block sits between a host-side request splitter and a set of flash dies. It holds single-page requests in a small pool of entries. Each entry carries an absolute deadline, a target die, a read/write flag and a page address. In every cycle the block can hand out one request. It picks the pending request with the smallest deadline whose die is not reported busy. If two deadlines are equal, the request that entered first goes first. An entry stays occupied after issue and is released only when its completion is reported with its tag.

When a page must be rebuilt from parity, the host hands over a rebuild: a mask of dies to read and a page address. These component reads bypass the deadline order and go out ahead of every queued request, lowest die first, and each one still waits for its die to be free. The block counts the reads that are outstanding. In the cycle after the last of them completes, it pulses a decode-start signal that carries the rebuilt page address. Only one rebuild is in flight at a time.

Top module: `flash_req_dispatch`

## Requirements
- R1: After reset no entry is occupied: `iss_valid`, `enq_full` and `dec_start` are 0 and `rb_ready` is 1.
- R2: An enqueue with `enq_valid` high while `enq_full` is low is stored in the lowest-numbered free entry, and that entry number is the tag shown on `iss_tag`. It can be issued from the following cycle onward.
- R3: Among pending, not-yet-issued entries whose die is idle, the one with the smallest deadline (unsigned compare) is the one issued.
- R4: Among entries with equal deadlines, the one enqueued earlier is issued first, whatever their entry numbers.
- R5: No request is issued to a die whose `die_busy` bit is 1. An older, earlier-deadline entry waits while its die is busy, and others go ahead of it.
- R6: At most one request is issued per cycle, and an issued entry is never issued again.
- R7: `enq_full` is 1 exactly when all entries are occupied. An enqueue while full is dropped and never issued.
- R8: An entry stays occupied from issue until `cmp_valid` with `cmp_rebuild`=0 and its tag. It is free in the next cycle, so `enq_full` falls one cycle after the completion.
- R9: A rebuild is accepted when `rb_valid` and `rb_ready` are both 1. Its component reads (`iss_rebuild`=1, `iss_write`=0, page `rb_page`) are issued before any queued request, regardless of deadline, lowest die number first. They are never issued to a busy die.
- R10: `rb_ready` is 0 while a rebuild is in flight. `dec_start` is a one-cycle pulse, with `dec_page` holding the rebuild page, in the cycle right after the completion (`cmp_rebuild`=1, die `cmp_die`) of the last component read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_deadline | input | DL_W | Absolute deadline of the new request |
| enq_die | input | DIE_W | Target die |
| enq_write | input | 1 | 1 = page write, 0 = page read |
| enq_page | input | PG_W | Page address |
| enq_full | output | 1 | All entries occupied, enqueue is dropped |
| rb_valid | input | 1 | Rebuild request |
| rb_mask | input | N_DIE | Dies whose page must be read for the rebuild |
| rb_page | input | PG_W | Page address used for the component reads |
| rb_ready | output | 1 | A rebuild can be accepted |
| die_busy | input | N_DIE | Per-die busy status |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_rebuild | output | 1 | Issued request is a rebuild component read |
| iss_tag | output | TAG_W | Entry number of the issued queued request |
| iss_die | output | DIE_W | Die of the issued request |
| iss_write | output | 1 | Issued request is a write |
| iss_page | output | PG_W | Page of the issued request |
| cmp_valid | input | 1 | Completion report |
| cmp_rebuild | input | 1 | Completion belongs to a rebuild read |
| cmp_tag | input | TAG_W | Entry number completing (queued request) |
| cmp_die | input | DIE_W | Die completing (rebuild read) |
| dec_start | output | 1 | All rebuild reads done, decode may begin |
| dec_page | output | PG_W | Page address of the finished rebuild |

## Verification
Two functions contend for the single issue slot. The first is the front-inserted rebuild read. The second is the deadline pick over queued entries. The bench loads a queued request with a very small deadline, accepts a rebuild, and then releases the dies so that both are eligible in the same cycle. It expects the rebuild read to win and the queued request to follow. A second same-cycle case is a die-busy mask that blocks one rebuild die while another is free. Here the free die's read must go first. The last completion is timed against the decode pulse, which must appear exactly one cycle later.

// File: rtl/fdisp_pkg.sv
package fdisp_pkg;
    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;
endpackage

// File: rtl/edf_pick.sv
// Combinational earliest-deadline selector with age tie-break.
module edf_pick #(
    parameter int N_ENT = 8,
    parameter int DL_W  = 16,
    localparam int TAG_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0]            elig,
    input  logic [N_ENT-1:0][DL_W-1:0]  dl,
    input  logic [N_ENT-1:0][N_ENT-1:0] older,
    output logic [N_ENT-1:0]            win,
    output logic                        any,
    output logic [TAG_W-1:0]            idx
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_row
        logic [N_ENT-1:0] beats;
        for (genvar j = 0; j < N_ENT; j++) begin : g_col
            if (i == j) begin : g_self
                assign beats[j] = 1'b1;
            end else begin : g_other
                assign beats[j] = !elig[j] || (dl[i] < dl[j]) ||
                                  ((dl[i] == dl[j]) && older[i][j]);
            end
        end
        assign win[i] = elig[i] && (&beats);
    end

    always_comb begin
        any = |win;
        idx = '0;
        for (int k = 0; k < N_ENT; k++) begin
            if (win[k]) idx = TAG_W'(k);
        end
    end
endmodule

// File: rtl/rb_track.sv
// Holds one rebuild: pending component reads, outstanding reads, decode pulse.
module rb_track
    import fdisp_pkg::*;
#(
    parameter int N_DIE = 4,
    parameter int PG_W  = 16,
    localparam int DIE_W = $clog2(N_DIE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [N_DIE-1:0] mask,
    input  logic [PG_W-1:0]  page_in,
    input  logic [N_DIE-1:0] die_busy,
    input  logic             cmp_hit,
    input  logic [DIE_W-1:0] cmp_die,
    output logic             ready,
    output logic             req,
    output logic [DIE_W-1:0] req_die,
    output op_e              req_op,
    output logic [PG_W-1:0]  page,
    output logic             dec
);
    typedef struct packed {
        logic             active;
        logic [N_DIE-1:0] pend;
        logic [N_DIE-1:0] outst;
        logic [PG_W-1:0]  page;
        logic             dec;
    } rb_st_t;

    rb_st_t s_q, s_d;

    always_comb begin
        req     = 1'b0;
        req_die = '0;
        for (int d = N_DIE - 1; d >= 0; d--) begin
            if (s_q.pend[d] && !die_busy[d]) begin
                req     = 1'b1;
                req_die = DIE_W'(d);
            end
        end
        req_op = OP_RD;

        s_d     = s_q;
        s_d.dec = 1'b0;
        if (acc) begin
            s_d.active = 1'b1;
            s_d.pend   = mask;
            s_d.outst  = '0;
            s_d.page   = page_in;
        end
        if (req) begin
            s_d.pend[req_die]  = 1'b0;
            s_d.outst[req_die] = 1'b1;
        end
        if (cmp_hit && s_q.active) s_d.outst[cmp_die] = 1'b0;
        if (s_d.active && (s_d.pend == '0) && (s_d.outst == '0)) begin
            s_d.active = 1'b0;
            s_d.dec    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready = !s_q.active && !s_q.dec;
    assign page  = s_q.page;
    assign dec   = s_q.dec;

    // R9: a component read never goes to a busy die
    a_r9_rb_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !die_busy[req_die]);
    // R10: decode pulse lasts one cycle
    a_r10_dec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> !dec);
    // R10: decode pulse only follows an in-flight rebuild
    a_r10_dec_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !$past(ready));
endmodule

// File: rtl/flash_req_dispatch.sv
module flash_req_dispatch
    import fdisp_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int N_DIE = 4,
    parameter int DL_W  = 16,
    parameter int PG_W  = 16,
    localparam int TAG_W = $clog2(N_ENT),
    localparam int DIE_W = $clog2(N_DIE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [DL_W-1:0]  enq_deadline,
    input  logic [DIE_W-1:0] enq_die,
    input  logic             enq_write,
    input  logic [PG_W-1:0]  enq_page,
    output logic             enq_full,
    input  logic             rb_valid,
    input  logic [N_DIE-1:0] rb_mask,
    input  logic [PG_W-1:0]  rb_page,
    output logic             rb_ready,
    input  logic [N_DIE-1:0] die_busy,
    output logic             iss_valid,
    output logic             iss_rebuild,
    output logic [TAG_W-1:0] iss_tag,
    output logic [DIE_W-1:0] iss_die,
    output logic             iss_write,
    output logic [PG_W-1:0]  iss_page,
    input  logic             cmp_valid,
    input  logic             cmp_rebuild,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic [DIE_W-1:0] cmp_die,
    output logic             dec_start,
    output logic [PG_W-1:0]  dec_page
);
    typedef struct packed {
        logic [N_ENT-1:0]            vld;
        logic [N_ENT-1:0]            issued;
        logic [N_ENT-1:0][DL_W-1:0]  dl;
        logic [N_ENT-1:0][DIE_W-1:0] die;
        logic [N_ENT-1:0]            wr;
        logic [N_ENT-1:0][PG_W-1:0]  page;
        logic [N_ENT-1:0][N_ENT-1:0] older;
    } q_st_t;

    q_st_t s_q, s_d;

    logic [N_ENT-1:0] elig, pick_win;
    logic             pick_any;
    logic [TAG_W-1:0] pick_idx;
    logic             free_any;
    logic [TAG_W-1:0] free_idx;
    logic             rb_req;
    logic [DIE_W-1:0] rb_die;
    op_e              rb_op;
    logic [PG_W-1:0]  rb_cur_page;
    logic             enq_fire, rb_acc;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            elig[i] = s_q.vld[i] && !s_q.issued[i] && !die_busy[s_q.die[i]];
        end
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!s_q.vld[i]) begin
                free_any = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end

    edf_pick #(.N_ENT(N_ENT), .DL_W(DL_W)) u_pick (
        .elig  (elig),
        .dl    (s_q.dl),
        .older (s_q.older),
        .win   (pick_win),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    assign rb_acc = rb_valid && rb_ready;

    rb_track #(.N_DIE(N_DIE), .PG_W(PG_W)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (rb_acc),
        .mask     (rb_mask),
        .page_in  (rb_page),
        .die_busy (die_busy),
        .cmp_hit  (cmp_valid && cmp_rebuild),
        .cmp_die  (cmp_die),
        .ready    (rb_ready),
        .req      (rb_req),
        .req_die  (rb_die),
        .req_op   (rb_op),
        .page     (rb_cur_page),
        .dec      (dec_start)
    );

    assign dec_page = rb_cur_page;
    assign enq_full = !free_any;
    assign enq_fire = enq_valid && free_any;

    // issue mux: rebuild reads first, then earliest deadline
    always_comb begin
        iss_valid   = 1'b0;
        iss_rebuild = 1'b0;
        iss_tag     = '0;
        iss_die     = '0;
        iss_write   = 1'b0;
        iss_page    = '0;
        if (rb_req) begin
            iss_valid   = 1'b1;
            iss_rebuild = 1'b1;
            iss_die     = rb_die;
            iss_write   = (rb_op == OP_WR);
            iss_page    = rb_cur_page;
        end else if (pick_any) begin
            iss_valid = 1'b1;
            iss_tag   = pick_idx;
            iss_die   = s_q.die[pick_idx];
            iss_write = s_q.wr[pick_idx];
            iss_page  = s_q.page[pick_idx];
        end
    end

    always_comb begin
        s_d = s_q;
        if (!rb_req && pick_any) s_d.issued[pick_idx] = 1'b1;
        if (cmp_valid && !cmp_rebuild && s_q.vld[cmp_tag] && s_q.issued[cmp_tag]) begin
            s_d.vld[cmp_tag]    = 1'b0;
            s_d.issued[cmp_tag] = 1'b0;
        end
        if (enq_fire) begin
            s_d.vld[free_idx]    = 1'b1;
            s_d.issued[free_idx] = 1'b0;
            s_d.dl[free_idx]     = enq_deadline;
            s_d.die[free_idx]    = enq_die;
            s_d.wr[free_idx]     = enq_write;
            s_d.page[free_idx]   = enq_page;
            for (int j = 0; j < N_ENT; j++) begin
                s_d.older[free_idx][j] = 1'b0;
                s_d.older[j][free_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: nothing goes to a busy die
    a_r5_idle_die: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !die_busy[iss_die]);
    // R6: selector never picks two entries
    a_r6_one_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_win));
    // R7: full persists until a queued request completes
    a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_full && !(cmp_valid && !cmp_rebuild)) |=> enq_full);
    // R9: a pending rebuild read never loses the slot to a queued request
    a_r9_rb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_rebuild) |-> !rb_req);
endmodule

// File: tb/sim_flash_req_dispatch.sv
module sim_flash_req_dispatch;
    localparam int N_ENT = 8;
    localparam int N_DIE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [15:0] enq_deadline = '0;
    logic [1:0]  enq_die = '0;
    logic        enq_write = 1'b0;
    logic [15:0] enq_page = '0;
    logic        enq_full;
    logic        rb_valid = 1'b0;
    logic [3:0]  rb_mask = '0;
    logic [15:0] rb_page = '0;
    logic        rb_ready;
    logic [3:0]  die_busy = 4'hF;
    logic        iss_valid, iss_rebuild, iss_write;
    logic [2:0]  iss_tag;
    logic [1:0]  iss_die;
    logic [15:0] iss_page;
    logic        cmp_valid = 1'b0;
    logic        cmp_rebuild = 1'b0;
    logic [2:0]  cmp_tag = '0;
    logic [1:0]  cmp_die = '0;
    logic        dec_start;
    logic [15:0] dec_page;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    flash_req_dispatch u0 (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_deadline(enq_deadline), .enq_die(enq_die),
        .enq_write(enq_write), .enq_page(enq_page), .enq_full(enq_full),
        .rb_valid(rb_valid), .rb_mask(rb_mask), .rb_page(rb_page), .rb_ready(rb_ready),
        .die_busy(die_busy),
        .iss_valid(iss_valid), .iss_rebuild(iss_rebuild), .iss_tag(iss_tag),
        .iss_die(iss_die), .iss_write(iss_write), .iss_page(iss_page),
        .cmp_valid(cmp_valid), .cmp_rebuild(cmp_rebuild), .cmp_tag(cmp_tag),
        .cmp_die(cmp_die), .dec_start(dec_start), .dec_page(dec_page)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic enq(input int dl, input int die, input bit wr, input int pg);
        enq_valid = 1'b1; enq_deadline = 16'(dl); enq_die = 2'(die);
        enq_write = wr; enq_page = 16'(pg);
        step();
        enq_valid = 1'b0;
    endtask

    task automatic cmp_q(input int tag);
        cmp_valid = 1'b1; cmp_rebuild = 1'b0; cmp_tag = 3'(tag);
        step();
        cmp_valid = 1'b0;
    endtask

    task automatic cmp_rb(input int die);
        cmp_valid = 1'b1; cmp_rebuild = 1'b1; cmp_die = 2'(die);
        step();
        cmp_valid = 1'b0; cmp_rebuild = 1'b0;
    endtask

    // check a queued-request issue in the current cycle, then commit it
    task automatic exp_q(input string req, input int tag, input int pg);
        #1;
        chk({req, " valid"}, 32'(iss_valid), 32'd1);
        chk({req, " rebuild"}, 32'(iss_rebuild), 32'd0);
        chk({req, " tag"}, 32'(iss_tag), 32'(tag));
        chk({req, " page"}, 32'(iss_page), 32'(pg));
        step();
    endtask

    task automatic t_reset();
        #1;
        chk("R1 iss_valid", 32'(iss_valid), 0);
        chk("R1 enq_full", 32'(enq_full), 0);
        chk("R1 dec_start", 32'(dec_start), 0);
        chk("R1 rb_ready", 32'(rb_ready), 1);
    endtask

    task automatic t_edf();
        die_busy = 4'hF;
        enq(50, 0, 0, 'h100);
        enq(20, 1, 1, 'h101);
        enq(35, 2, 0, 'h102);
        die_busy = 4'h0;
        #1 chk("R3 write flag", 32'(iss_write), 1);
        exp_q("R3 first", 1, 'h101);
        exp_q("R3 second", 2, 'h102);
        exp_q("R2 third", 0, 'h100);
        #1 chk("R6 no reissue", 32'(iss_valid), 0);
        cmp_q(0); cmp_q(1); cmp_q(2);
    endtask

    task automatic t_tie();
        die_busy = 4'hF;
        enq(5, 0, 0, 'h200);
        enq(30, 1, 0, 'h201);
        die_busy = 4'h0;
        exp_q("R3 tie setup", 0, 'h200);
        die_busy = 4'hF;
        cmp_q(0);
        enq(30, 2, 0, 'h202);   // lands in entry 0 but is younger
        die_busy = 4'h0;
        exp_q("R4 older first", 1, 'h201);
        exp_q("R4 younger next", 0, 'h202);
        cmp_q(0); cmp_q(1);
    endtask

    task automatic t_busy();
        die_busy = 4'hF;
        enq(5, 0, 0, 'h300);
        enq(9, 1, 0, 'h301);
        die_busy = 4'b0001;
        #1 chk("R5 die", 32'(iss_die), 1);
        exp_q("R5 skip busy", 1, 'h301);
        #1 chk("R5 waits", 32'(iss_valid), 0);
        step();
        die_busy = 4'h0;
        exp_q("R5 released", 0, 'h300);
        cmp_q(0); cmp_q(1);
    endtask

    task automatic t_full();
        die_busy = 4'hF;
        for (int i = 0; i < N_ENT; i++) enq(200 - i * 10, i % N_DIE, 0, 'h400 + i);
        #1 chk("R7 full set", 32'(enq_full), 1);
        enq(1, 3, 0, 'h4FF);    // must be dropped
        die_busy = 4'h0;
        for (int i = N_ENT - 1; i >= 0; i--) exp_q("R7 order", i, 'h400 + i);
        #1 chk("R7 dropped", 32'(iss_valid), 0);
        chk("R8 still full", 32'(enq_full), 1);
        cmp_q(3);
        chk("R8 freed", 32'(enq_full), 0);
        for (int i = 0; i < N_ENT; i++) if (i != 3) cmp_q(i);
    endtask

    // rebuild reads and a queued request eligible in the same cycle
    task automatic t_rebuild();
        die_busy = 4'hF;
        enq(1, 0, 0, 'h500);
        #1 chk("R10 ready idle", 32'(rb_ready), 1);
        rb_valid = 1'b1; rb_mask = 4'b0110; rb_page = 16'h0077;
        step();
        rb_valid = 1'b0;
        chk("R10 ready busy", 32'(rb_ready), 0);
        die_busy = 4'b0100;
        #1;
        chk("R9 rb first", 32'(iss_rebuild), 1);
        chk("R9 rb die", 32'(iss_die), 1);
        chk("R9 rb page", 32'(iss_page), 'h77);
        step();
        die_busy = 4'h0;
        #1;
        chk("R9 rb second", 32'(iss_rebuild), 1);
        chk("R9 rb die2", 32'(iss_die), 2);
        step();
        exp_q("R9 queued after", 0, 'h500);
        cmp_rb(1);
        chk("R10 not yet", 32'(dec_start), 0);
        cmp_rb(2);
        chk("R10 dec", 32'(dec_start), 1);
        chk("R10 dec page", 32'(dec_page), 'h77);
        step();
        chk("R10 pulse end", 32'(dec_start), 0);
        chk("R10 ready again", 32'(rb_ready), 1);
        cmp_q(0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        die_busy = 4'h0;
        step();
        t_reset();
        t_edf();
        t_tie();
        t_busy();
        t_full();
        t_rebuild();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule